// File: doc/BRIEF.md
# Configurable Multiplexed-Bus I/O Port

This block is an eight-pin general-purpose port for a microcontroller whose low address byte and data share one bus. Each pin is configured on its own. In register mode the pin works as a normal I/O line. A direction bit picks input or output, and a data bit sets the level it drives. In address mode the pin instead drives one bit of the low address byte. That byte is held in an internal latch that captures the shared bus when the address strobe ends.

Software reaches the configuration through a small register interface. The interface writes one byte at a time, and a per-bit write mask selects which bits change. Software can also read back every configuration register and the synchronised level of each pin. A per-pin open-drain option limits a pin to pulling low. The pad itself is modelled as separate out, output-enable and in vectors, so the tri-state buffer sits outside the block.

Top module: `mux_io_port`

## Requirements
- R1: In register mode (mode bit 0), a pin with direction bit 0 has its output enable low, and a pin with direction bit 1 has its output enable high (push-pull).
- R2: A push-pull pin in register mode with direction 1 drives `pad_out` equal to its data-register bit, one cycle after the write.
- R3: Reading register address 4 returns the level seen on `pad_in` two rising edges earlier, whether the port or an outside source drove it.
- R4: After reset the direction, data, mode and open-drain registers read 0 and every `pad_oe` bit is 0.
- R5: The address latch loads `bus_ad` at the first rising clock edge where `ale` is low after having been high. Bus changes while `ale` stays low or stays high leave the latch unchanged.
- R6: A pin with mode bit 1 drives bit n of the address latch on pin n, with its output enabled whatever its direction bit says.
- R7: A pin with open-drain bit 1 never drives high: when its selected source bit is 1 its output enable is low, and when that bit is 0 it drives 0.
- R8: A write with `reg_wr` high changes only the bits of the addressed register whose `reg_wmask` bit is 1. The register addresses are 0 for direction, 1 for data, 2 for mode and 3 for open-drain.
- R9: Writes to address 4 (pin level) or to addresses 5 to 7 change no register, and reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ad | input | 8 | Low byte of the shared address/data bus |
| ale | input | 1 | Address strobe; the latch loads when it ends |
| reg_wr | input | 1 | Register write request |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_wmask | input | 8 | Per-bit write enable |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven to each pad |
| pad_oe | output | 8 | Per-pad output enable |

## Verification
The hardest situation to reach is an open-drain pin in address mode while the latch reloads. The pin's output enable then has to toggle with address bits rather than with any register write. The bench first loads a known address, then switches pins into address mode with open-drain set. It next ends strobes with differing bus bytes, so each enable flips one cycle after the strobe falls. A long mixed phase adds random masked writes, random strobe pulses and an outside driver on released pins, and a reference model checks every cycle.

// File: rtl/iop_pkg.sv
package iop_pkg;
   localparam int unsigned REG_AW = 3;
   typedef enum logic [REG_AW-1:0] {
      RA_DIR  = 3'd0,
      RA_DATA = 3'd1,
      RA_MODE = 3'd2,
      RA_ODEN = 3'd3,
      RA_PIN  = 3'd4
   } reg_addr_e;
endpackage

// File: rtl/iop_cfg_regs.sv
module iop_cfg_regs
   import iop_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [WIDTH-1:0]  wdata,
   input  logic [WIDTH-1:0]  wmask,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  data_q,
   output logic [WIDTH-1:0]  mode_q,
   output logic [WIDTH-1:0]  oden_q
);
   localparam int unsigned NREG = 4;

   logic [WIDTH-1:0] regs_q [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit;
      assign hit = wr && (addr == REG_AW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) regs_q[r] <= '0;
         else if (hit) regs_q[r] <= (regs_q[r] & ~wmask) | (wdata & wmask);
      end
   end

   assign dir_q  = regs_q[RA_DIR];
   assign data_q = regs_q[RA_DATA];
   assign mode_q = regs_q[RA_MODE];
   assign oden_q = regs_q[RA_ODEN];
endmodule

// File: rtl/iop_addr_latch.sv
module iop_addr_latch #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic [WIDTH-1:0] bus,
   output logic [WIDTH-1:0] addr_q
);
   logic strobe_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_d <= 1'b0;
         addr_q   <= '0;
      end else begin
         strobe_d <= strobe;
         if (strobe_d && !strobe) addr_q <= bus;
      end
   end
endmodule

// File: rtl/iop_sync.sv
module iop_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= '0;
      else        chain_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/iop_pin_cell.sv
module iop_pin_cell #(
   parameter bit OPEN_DRAIN_EN = 1'b1
) (
   input  logic addr_mode,
   input  logic dir_out,
   input  logic data_bit,
   input  logic addr_bit,
   input  logic oden,
   output logic out,
   output logic oe
);
   logic src;
   logic drive;

   assign src   = addr_mode ? addr_bit : data_bit;
   assign drive = addr_mode | dir_out;

   if (OPEN_DRAIN_EN) begin : g_od
      assign out = oden ? 1'b0 : src;
      assign oe  = drive & ~(oden & src);
   end else begin : g_pp
      logic unused_oden;
      assign unused_oden = oden;
      assign out = src;
      assign oe  = drive;
   end
endmodule

// File: rtl/mux_io_port.sv
module mux_io_port
   import iop_pkg::*;
#(
   parameter int unsigned PORT_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          OPEN_DRAIN_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] bus_ad,
   input  logic              ale,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [PORT_W-1:0] reg_wdata,
   input  logic [PORT_W-1:0] reg_wmask,
   output logic [PORT_W-1:0] reg_rdata,
   input  logic [PORT_W-1:0] pad_in,
   output logic [PORT_W-1:0] pad_out,
   output logic [PORT_W-1:0] pad_oe
);
   initial begin
      assert (PORT_W >= 1 && PORT_W <= 32)
         else $error("mux_io_port: PORT_W must be 1..32");
      assert (SYNC_STAGES >= 2)
         else $error("mux_io_port: SYNC_STAGES must be at least 2");
   end

   logic [PORT_W-1:0] dir_q, data_q, mode_q, oden_q;
   logic [PORT_W-1:0] addr_q;
   logic [PORT_W-1:0] pin_q;

   iop_cfg_regs #(.WIDTH(PORT_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (reg_wr),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .wmask  (reg_wmask),
      .dir_q  (dir_q),
      .data_q (data_q),
      .mode_q (mode_q),
      .oden_q (oden_q)
   );

   iop_addr_latch #(.WIDTH(PORT_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (ale),
      .bus    (bus_ad),
      .addr_q (addr_q)
   );

   iop_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_q)
   );

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      iop_pin_cell #(.OPEN_DRAIN_EN(OPEN_DRAIN_EN)) u_cell (
         .addr_mode (mode_q[i]),
         .dir_out   (dir_q[i]),
         .data_bit  (data_q[i]),
         .addr_bit  (addr_q[i]),
         .oden      (oden_q[i]),
         .out       (pad_out[i]),
         .oe        (pad_oe[i])
      );
   end

   always_comb begin
      unique case (reg_addr)
         RA_DIR:  reg_rdata = dir_q;
         RA_DATA: reg_rdata = data_q;
         RA_MODE: reg_rdata = mode_q;
         RA_ODEN: reg_rdata = oden_q;
         RA_PIN:  reg_rdata = pin_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/mux_io_port_checker.sv
module mux_io_port_checker #(
   parameter int unsigned PORT_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ale,
   input logic [PORT_W-1:0] bus_ad,
   input logic [PORT_W-1:0] pad_in,
   input logic [PORT_W-1:0] pad_out,
   input logic [PORT_W-1:0] pad_oe,
   input logic [PORT_W-1:0] dir_q,
   input logic [PORT_W-1:0] mode_q,
   input logic [PORT_W-1:0] oden_q,
   input logic [PORT_W-1:0] addr_q,
   input logic [PORT_W-1:0] pin_q
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~mode_q & ~dir_q) == '0)); // R1

   AST_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & mode_q & ~oden_q) == (mode_q & ~oden_q))); // R6

   AST_ADDR_BIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (((pad_out ^ addr_q) & mode_q & ~oden_q) == '0)); // R6

   AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & pad_oe & oden_q) == '0)); // R7

   AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |=> (addr_q == $past(bus_ad))); // R5

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(ale) |=> $stable(addr_q)); // R5

   if (SYNC_STAGES == 2) begin : g_sync_chk
      AST_PIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst == 2'd3) |-> (pin_q == $past(pad_in, 2))); // R3
   end
endmodule

bind mux_io_port mux_io_port_checker #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ale     (ale),
   .bus_ad  (bus_ad),
   .pad_in  (pad_in),
   .pad_out (pad_out),
   .pad_oe  (pad_oe),
   .dir_q   (dir_q),
   .mode_q  (mode_q),
   .oden_q  (oden_q),
   .addr_q  (addr_q),
   .pin_q   (pin_q)
);

// File: tb/mux_io_port_bench.sv
module mux_io_port_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] bus_ad = '0;
   logic         ale = 1'b0;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_wmask = '0;
   logic [W-1:0] reg_rdata;
   logic [W-1:0] pad_in;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;
   logic [W-1:0] ext_drv = '0;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   // outside world: port wins where it drives, otherwise the external source
   assign pad_in = (pad_out & pad_oe) | (ext_drv & ~pad_oe);

   mux_io_port u_mux_io_port (
      .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .ale(ale),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // ---------------- behavioural reference model ----------------
   logic [W-1:0] m_dir, m_data, m_mode, m_od, m_latch;
   logic         m_ale_prev;
   logic [W-1:0] m_hist[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_dir <= '0; m_data <= '0; m_mode <= '0; m_od <= '0;
         m_latch <= '0; m_ale_prev <= 1'b0;
         m_hist = {};
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               3'd0: m_dir  <= (m_dir  & ~reg_wmask) | (reg_wdata & reg_wmask);
               3'd1: m_data <= (m_data & ~reg_wmask) | (reg_wdata & reg_wmask);
               3'd2: m_mode <= (m_mode & ~reg_wmask) | (reg_wdata & reg_wmask);
               3'd3: m_od   <= (m_od   & ~reg_wmask) | (reg_wdata & reg_wmask);
               default: ;
            endcase
         end
         if (m_ale_prev && !ale) m_latch <= bus_ad;
         m_ale_prev <= ale;
         m_hist.push_back(pad_in);
         if (m_hist.size() > 2) void'(m_hist.pop_front());
      end
   end

   function automatic logic [W-1:0] exp_oe();
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) begin
         logic src;
         src  = m_mode[i] ? m_latch[i] : m_data[i];
         r[i] = (m_mode[i] | m_dir[i]) & ~(m_od[i] & src);
      end
      return r;
   endfunction

   function automatic logic [W-1:0] exp_out();
      logic [W-1:0] r;
      for (int i = 0; i < W; i++)
         r[i] = m_od[i] ? 1'b0 : (m_mode[i] ? m_latch[i] : m_data[i]);
      return r;
   endfunction

   function automatic logic [W-1:0] exp_rd();
      case (reg_addr)
         3'd0: return m_dir;
         3'd1: return m_data;
         3'd2: return m_mode;
         3'd3: return m_od;
         3'd4: return (m_hist.size() == 2) ? m_hist[0] : '0;
         default: return '0;
      endcase
   endfunction

   task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %02h expected %02h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cycles++;
         check("R1", "pad_oe", pad_oe, exp_oe());
         check("R2", "pad_out on enabled pins", pad_out & pad_oe, exp_out() & exp_oe());
         check(reg_addr == 3'd4 ? "R3" : "R8", "reg_rdata", reg_rdata, exp_rd());
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wr_reg(logic [2:0] a, logic [W-1:0] d, logic [W-1:0] m);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_wmask = m;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_expect(string req, logic [2:0] a, logic [W-1:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(req, "register read", reg_rdata, exp);
   endtask

   task automatic addr_cycle(logic [W-1:0] a);
      @(negedge clk); bus_ad = a; ale = 1'b1;
      @(negedge clk); ale = 1'b0;
      @(negedge clk); bus_ad = ~a;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R4: reset state
      check("R4", "pad_oe in reset", pad_oe, 8'h00);
      rst_n = 1'b1;
      rd_expect("R4", 3'd0, 8'h00);
      rd_expect("R4", 3'd1, 8'h00);
      rd_expect("R4", 3'd2, 8'h00);
      rd_expect("R4", 3'd3, 8'h00);
      check("R4", "pad_oe after reset", pad_oe, 8'h00);

      // R1/R2: direction and data
      wr_reg(3'd1, 8'hA5, 8'hFF);
      wr_reg(3'd0, 8'hF0, 8'hFF);
      #1 check("R1", "pad_oe dir F0", pad_oe, 8'hF0);
      check("R2", "pad_out upper", pad_out & 8'hF0, 8'hA0);

      // R3: external source on inputs, port on outputs
      ext_drv = 8'h3C;
      repeat (3) @(negedge clk);
      rd_expect("R3", 3'd4, 8'hAC);

      // R8: masked write touches only selected bits
      wr_reg(3'd1, 8'h00, 8'h30);
      rd_expect("R8", 3'd1, 8'h85);
      // R9: writes to pin register / unused addresses are ignored
      wr_reg(3'd4, 8'hFF, 8'hFF);
      wr_reg(3'd6, 8'hFF, 8'hFF);
      rd_expect("R9", 3'd0, 8'hF0);
      rd_expect("R9", 3'd1, 8'h85);
      rd_expect("R9", 3'd2, 8'h00);
      rd_expect("R9", 3'd3, 8'h00);
      rd_expect("R9", 3'd6, 8'h00);

      // R5/R6: address latch and position-locked address pins
      addr_cycle(8'h5A);
      wr_reg(3'd0, 8'h00, 8'hFF);
      wr_reg(3'd2, 8'h0F, 8'hFF);
      #1 check("R6", "pad_oe addr mode dir 0", pad_oe, 8'h0F);
      check("R6", "pad_out low nibble = A[3:0]", pad_out & 8'h0F, 8'h0A);
      // bus moves with ale low: no capture
      @(negedge clk); bus_ad = 8'hFF;
      repeat (2) @(negedge clk);
      #1 check("R5", "latch holds with ale low", pad_out & 8'h0F, 8'h0A);
      // bus moves with ale high: no capture until ale falls
      @(negedge clk); ale = 1'b1; bus_ad = 8'h03;
      @(negedge clk); bus_ad = 8'h0C;
      #1 check("R5", "latch holds with ale high", pad_out & 8'h0F, 8'h0A);
      @(negedge clk); ale = 1'b0; bus_ad = 8'h06;
      @(negedge clk); bus_ad = 8'h00;
      #1 check("R5", "latch loads at fall", pad_out & 8'h0F, 8'h06);

      // R7: open-drain on address pins and data pins
      wr_reg(3'd3, 8'hFF, 8'hFF);
      #1 check("R7", "od addr-mode oe", pad_oe, 8'h09);
      check("R7", "od drives low only", pad_out & pad_oe, 8'h00);
      addr_cycle(8'h0F);
      #1 check("R7", "od release on ones", pad_oe & 8'h0F, 8'h00);
      wr_reg(3'd2, 8'h00, 8'hFF);
      wr_reg(3'd0, 8'hFF, 8'hFF);
      wr_reg(3'd1, 8'h55, 8'hFF);
      #1 check("R7", "od data oe", pad_oe, 8'hAA);

      // mixed random phase, model compared every clock
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         reg_wr    = ($urandom_range(0, 3) == 0);
         reg_addr  = 3'($urandom_range(0, 7));
         reg_wdata = 8'($urandom);
         reg_wmask = 8'($urandom);
         bus_ad    = 8'($urandom);
         if ($urandom_range(0, 4) == 0) ale = ~ale;
         if ($urandom_range(0, 7) == 0) ext_drv = 8'($urandom);
      end
      @(negedge clk); reg_wr = 1'b0;
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule